// File: doc/BRIEF.md
# Pixel Word Unpacker

The block sits between a frame-buffer FIFO and a panel data bus. It takes one 32-bit memory word at a time and emits the pixels in that word as a stream of 24-bit colour values, one per output handshake. A three-bit depth code says how many pixels the word holds and how each one turns into colour. Depths of 8 bits or less look up a palette. Depths of 16 and 24 bits carry colour directly and are widened to 8 bits per channel.

Three independent order controls shape the output. One says whether bytes (and halfwords) are taken from the low or the high end of the word. One says whether sub-byte pixels are taken from the low or the high end of their byte. One swaps the red and blue channels. The depth and order controls are captured together with the word, so software may change them at any time without disturbing a word already in progress. The palette is loaded through a simple synchronous write port.

Both sides use valid/ready handshakes. A word is held until its last pixel has been taken, and the next word may be accepted in that same cycle.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset, `pix_valid_o` is low and `word_ready_o` is high.
- R2: Depth codes give these pixels per word: 000 gives 32 (1 bpp), 001 gives 16 (2 bpp), 010 gives 8 (4 bpp), 011 gives 4 (8 bpp), 100 gives 2, 110 gives 2, 101 gives 1 and 111 gives 1. `word_ready_o` is high when no word is held, or when the held word's last pixel is taken in the same cycle. A word taken when `word_valid_i` and `word_ready_o` are both high makes `pix_valid_o` high on the next cycle.
- R3: Pixel n of a word is located as follows. At depth d ≤ 8 it lies in byte b = n/(8/d), and that byte is bits [8b+7:8b] when `byte_hi_first_i`=0, or bits [31-8b:24-8b] when it is 1. Its slot is j = n mod (8/d), found at bit offset j·d inside the byte when `pix_hi_first_i`=0, or at 8-(j+1)·d when it is 1. At 16 bpp, pixel 0 is bits [15:0] and pixel 1 is bits [31:16] when `byte_hi_first_i`=0, and the two are reversed when it is 1.
- R4: At depths 000 to 011, the pixel value is a palette index. The output is the entry, stored as {R[23:16],G[15:8],B[7:0]}. A write with `pal_we_i` high updates the entry at the next clock edge.
- R5: Code 100 reads a 16-bit value as x:R5:G5:B5 (R in bits 14:10, G in 9:5, B in 4:0, bit 15 ignored). Each channel becomes {c, c[4:2]}.
- R6: Code 110 reads R5:G6:B5 (R in 15:11, G in 10:5, B in 4:0). R and B become {c, c[4:2]} and G becomes {g, g[5:4]}.
- R7: Code 101 takes bits [23:0] as {R,G,B}. Bits [31:24] are ignored.
- R8: Code 111 outputs black (all zero) for its single pixel.
- R9: With the swap control low the output is {R,G,B}. With it high the output is {B,G,R}.
- R10: Depth and order controls are sampled only when a word is taken. Changes to them while the word is held have no effect on its pixels.
- R11: While `pix_valid_o` is high and `pix_ready_i` is low, the valid stays high and `pix_o` holds its value, unless the palette is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| depth_i | input | 3 | Depth code, sampled with the word |
| byte_hi_first_i | input | 1 | Take bytes/halfwords from the high end of the word |
| pix_hi_first_i | input | 1 | Take sub-byte pixels from the high end of the byte |
| swap_rb_i | input | 1 | Exchange red and blue on output |
| word_valid_i | input | 1 | Input word valid |
| word_i | input | 32 | Input memory word |
| word_ready_o | output | 1 | Block can take a word |
| pal_we_i | input | 1 | Palette write strobe |
| pal_addr_i | input | PAL_AW | Palette write address |
| pal_data_i | input | 24 | Palette entry {R,G,B} |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 24 | Pixel colour |
| pix_ready_i | input | 1 | Output pixel taken |

## Verification
The bench builds the block with the default 8-bit palette address. This makes the whole palette writable, so every index value at 8 bpp reaches a distinct entry, and palette writes can land in the middle of a stall. Every depth code is run under all eight combinations of the three order controls, with random stalls on both handshakes. The depth and order inputs are scrambled on cycles when no new word is offered, which tests that they are sampled only with the word. A back-to-back word taken in the same cycle as the last pixel is reached naturally at the one-pixel depths.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int CH_W   = 8;
  localparam int RGB_W  = 3 * CH_W;

  typedef enum logic [2:0] {
    DEPTH_1   = 3'd0,
    DEPTH_2   = 3'd1,
    DEPTH_4   = 3'd2,
    DEPTH_8   = 3'd3,
    DEPTH_16  = 3'd4,
    DEPTH_24  = 3'd5,
    DEPTH_565 = 3'd6,
    DEPTH_RSV = 3'd7
  } depth_e;

  typedef struct packed {
    depth_e depth;
    logic   byte_hi_first;
    logic   pix_hi_first;
    logic   swap_rb;
  } cfg_t;

  function automatic logic [IDX_W:0] pix_per_word(depth_e d);
    case (d)
      DEPTH_1:             return (IDX_W+1)'(32);
      DEPTH_2:             return (IDX_W+1)'(16);
      DEPTH_4:             return (IDX_W+1)'(8);
      DEPTH_8:             return (IDX_W+1)'(4);
      DEPTH_16, DEPTH_565: return (IDX_W+1)'(2);
      default:             return (IDX_W+1)'(1);
    endcase
  endfunction
endpackage

// File: rtl/pxu_palette.sv
module pxu_palette #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pxu_extract.sv
module pxu_extract
  import pxu_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  cfg_t              cfg_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [RGB_W-1:0]  raw_o
);
  logic [7:0]  sub_val [4];
  logic [15:0] half_val;

  // one selector per sub-word depth: 1, 2, 4, 8 bpp
  for (genvar g = 0; g < 4; g++) begin : g_sub
    localparam int BPP  = 1 << g;
    localparam int PPB  = 8 / BPP;
    localparam int MASK = (1 << BPP) - 1;

    logic [1:0] byte_idx, byte_sel;
    logic [2:0] slot, slot_eff;
    logic [4:0] bit_pos;

    always_comb begin
      byte_idx    = 2'(idx_i >> (3 - g));
      slot        = 3'(idx_i) & 3'(PPB - 1);
      byte_sel    = cfg_i.byte_hi_first ? ~byte_idx : byte_idx;
      slot_eff    = cfg_i.pix_hi_first ? (slot ^ 3'(PPB - 1)) : slot;
      bit_pos     = 5'({byte_sel, 3'b000}) + 5'(slot_eff << g);
      sub_val[g]  = 8'(word_i >> bit_pos) & 8'(MASK);
    end
  end

  always_comb begin
    if (idx_i[0] ^ cfg_i.byte_hi_first) half_val = word_i[31:16];
    else                                half_val = word_i[15:0];
  end

  always_comb begin
    case (cfg_i.depth)
      DEPTH_1:             raw_o = RGB_W'(sub_val[0]);
      DEPTH_2:             raw_o = RGB_W'(sub_val[1]);
      DEPTH_4:             raw_o = RGB_W'(sub_val[2]);
      DEPTH_8:             raw_o = RGB_W'(sub_val[3]);
      DEPTH_16, DEPTH_565: raw_o = RGB_W'(half_val);
      DEPTH_24:            raw_o = word_i[RGB_W-1:0];
      default:             raw_o = '0;
    endcase
  end
endmodule

// File: rtl/pxu_color.sv
module pxu_color
  import pxu_pkg::*;
(
  input  depth_e           depth_i,
  input  logic             swap_rb_i,
  input  logic [RGB_W-1:0] raw_i,
  input  logic [RGB_W-1:0] pal_rgb_i,
  output logic [RGB_W-1:0] rgb_o
);
  logic [CH_W-1:0] r, g, b;

  always_comb begin
    case (depth_i)
      DEPTH_1, DEPTH_2, DEPTH_4, DEPTH_8: begin
        r = pal_rgb_i[23:16];
        g = pal_rgb_i[15:8];
        b = pal_rgb_i[7:0];
      end
      DEPTH_16: begin
        r = {raw_i[14:10], raw_i[14:12]};
        g = {raw_i[9:5],   raw_i[9:7]};
        b = {raw_i[4:0],   raw_i[4:2]};
      end
      DEPTH_565: begin
        r = {raw_i[15:11], raw_i[15:13]};
        g = {raw_i[10:5],  raw_i[10:9]};
        b = {raw_i[4:0],   raw_i[4:2]};
      end
      DEPTH_24: begin
        r = raw_i[23:16];
        g = raw_i[15:8];
        b = raw_i[7:0];
      end
      default: begin
        r = '0;
        g = '0;
        b = '0;
      end
    endcase
  end

  assign rgb_o = swap_rb_i ? {b, g, r} : {r, g, b};
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import pxu_pkg::*;
#(
  parameter int PAL_AW = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          depth_i,
  input  logic                byte_hi_first_i,
  input  logic                pix_hi_first_i,
  input  logic                swap_rb_i,
  input  logic                word_valid_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic                word_ready_o,
  input  logic                pal_we_i,
  input  logic [PAL_AW-1:0]   pal_addr_i,
  input  logic [RGB_W-1:0]    pal_data_i,
  output logic                pix_valid_o,
  output logic [RGB_W-1:0]    pix_o,
  input  logic                pix_ready_i
);
  logic              full_q;
  logic [WORD_W-1:0] word_q;
  cfg_t              cfg_q;
  logic [IDX_W-1:0]  idx_q;

  logic             last, pix_fire, word_fire;
  logic [RGB_W-1:0] raw, pal_rgb;

  assign last         = ({1'b0, idx_q} == pix_per_word(cfg_q.depth) - 1'b1);
  assign pix_fire     = full_q & pix_ready_i;
  assign word_ready_o = ~full_q | (pix_fire & last);
  assign word_fire    = word_valid_i & word_ready_o;
  assign pix_valid_o  = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      word_q <= '0;
      cfg_q  <= '0;
      idx_q  <= '0;
    end else if (word_fire) begin
      full_q <= 1'b1;
      word_q <= word_i;
      cfg_q  <= '{depth: depth_e'(depth_i), byte_hi_first: byte_hi_first_i,
                  pix_hi_first: pix_hi_first_i, swap_rb: swap_rb_i};
      idx_q  <= '0;
    end else if (pix_fire) begin
      if (last) begin
        full_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  pxu_extract u_extract (
    .word_i (word_q),
    .cfg_i  (cfg_q),
    .idx_i  (idx_q),
    .raw_o  (raw)
  );

  pxu_palette #(.AW(PAL_AW), .DW(RGB_W)) u_palette (
    .clk_i   (clk_i),
    .we_i    (pal_we_i),
    .waddr_i (pal_addr_i),
    .wdata_i (pal_data_i),
    .raddr_i (raw[PAL_AW-1:0]),
    .rdata_o (pal_rgb)
  );

  pxu_color u_color (
    .depth_i   (cfg_q.depth),
    .swap_rb_i (cfg_q.swap_rb),
    .raw_i     (raw),
    .pal_rgb_i (pal_rgb),
    .rgb_o     (pix_o)
  );

  // R2
  idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> ({1'b0, idx_q} < pix_per_word(cfg_q.depth)));

  // R2
  word_to_pix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && word_ready_o) |=> pix_valid_o);

  // R11
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i && !pal_we_i) |=> (pix_valid_o && $stable(pix_o)));

  // R8
  rsv_black_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && cfg_q.depth == DEPTH_RSV) |-> (pix_o == '0));

  // R7
  single_pix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && pix_ready_i && cfg_q.depth == DEPTH_24 && !word_valid_i) |=> !pix_valid_o);
endmodule

// File: tb/sim_pixel_unpacker.sv
`timescale 1ns/1ps
module sim_pixel_unpacker;
  localparam int PAL_AW = 8;
  localparam int WORDS_PER_COMBO = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  depth_i = '0;
  logic        byte_hi_first_i = 1'b0, pix_hi_first_i = 1'b0, swap_rb_i = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        word_ready_o;
  logic        pal_we_i = 1'b0;
  logic [7:0]  pal_addr_i = '0;
  logic [23:0] pal_data_i = '0;
  logic        pix_valid_o;
  logic [23:0] pix_o;
  logic        pix_ready_i = 1'b0;

  int vectors = 0, fails = 0;
  bit done = 0;

  logic [23:0] pal_m [256];
  logic [31:0] cur_w;
  int cur_mode, cur_idx, rem;
  bit cur_bhi, cur_phi, cur_swp;

  always #2.5 clk_i = ~clk_i;

  pixel_unpacker #(.PAL_AW(PAL_AW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .depth_i(depth_i),
    .byte_hi_first_i(byte_hi_first_i), .pix_hi_first_i(pix_hi_first_i),
    .swap_rb_i(swap_rb_i), .word_valid_i(word_valid_i), .word_i(word_i),
    .word_ready_o(word_ready_o), .pal_we_i(pal_we_i), .pal_addr_i(pal_addr_i),
    .pal_data_i(pal_data_i), .pix_valid_o(pix_valid_o), .pix_o(pix_o),
    .pix_ready_i(pix_ready_i)
  );

  function automatic int ppw(int mode);
    if (mode < 4) return 32 >> mode;
    if (mode == 4 || mode == 6) return 2;
    return 1;
  endfunction

  function automatic logic [23:0] exp_pix(logic [31:0] w, int mode, bit bhi,
                                          bit phi, bit swp, int idx);
    int r, g, b, bpp, per, bi, j, sh, v;
    logic [7:0]  byt;
    logic [15:0] hw;
    r = 0; g = 0; b = 0;
    if (mode < 4) begin
      bpp = 1 << mode;
      per = 8 / bpp;
      bi  = idx / per;
      j   = idx % per;
      byt = bhi ? w[8*(3-bi) +: 8] : w[8*bi +: 8];
      sh  = phi ? 8 - bpp*(j+1) : bpp*j;
      v   = (int'(byt) >> sh) & ((1 << bpp) - 1);
      r = int'(pal_m[v][23:16]); g = int'(pal_m[v][15:8]); b = int'(pal_m[v][7:0]);
    end else if (mode == 4 || mode == 6) begin
      hw = ((idx == 0) != bhi) ? w[15:0] : w[31:16];
      if (mode == 4) begin
        r = (int'(hw) >> 10) & 31; g = (int'(hw) >> 5) & 31; b = int'(hw) & 31;
        g = (g << 3) | (g >> 2);
      end else begin
        r = (int'(hw) >> 11) & 31; g = (int'(hw) >> 5) & 63; b = int'(hw) & 31;
        g = (g << 2) | (g >> 4);
      end
      r = (r << 3) | (r >> 2);
      b = (b << 3) | (b >> 2);
    end else if (mode == 5) begin
      r = int'(w[23:16]); g = int'(w[15:8]); b = int'(w[7:0]);
    end
    if (swp) return {8'(b), 8'(g), 8'(r)};
    return {8'(r), 8'(g), 8'(b)};
  endfunction

  function automatic string mode_tag(int mode);
    case (mode)
      4: return "R5";
      5: return "R7";
      6: return "R6";
      7: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic run_combo(int mode, int combo);
    int sent;
    bit exp_valid, exp_wr;
    logic [23:0] e;
    sent = 0;
    while (sent < WORDS_PER_COMBO || rem > 0) begin
      @(negedge clk_i);
      word_valid_i = (sent < WORDS_PER_COMBO) && ($urandom % 4 != 0);
      word_i = $urandom;
      if (word_valid_i) begin
        depth_i = 3'(mode);
        byte_hi_first_i = combo[2];
        pix_hi_first_i  = combo[1];
        swap_rb_i       = combo[0];
      end else begin
        // R10: controls scrambled while a word is held
        depth_i = 3'($urandom);
        {byte_hi_first_i, pix_hi_first_i, swap_rb_i} = 3'($urandom);
      end
      pix_ready_i = ($urandom % 3 != 0);
      pal_we_i    = ($urandom % 16 == 0);
      pal_addr_i  = 8'($urandom);
      pal_data_i  = 24'($urandom);
      #1;
      exp_valid = (rem > 0);
      exp_wr    = (rem == 0) || (rem == 1 && pix_ready_i);
      vectors++;
      if (pix_valid_o !== exp_valid) begin
        fails++;
        $display("FAIL R2 R11 pix_valid_o: actual %0b expected %0b", pix_valid_o, exp_valid);
      end
      vectors++;
      if (word_ready_o !== exp_wr) begin
        fails++;
        $display("FAIL R2 word_ready_o: actual %0b expected %0b", word_ready_o, exp_wr);
      end
      if (exp_valid && pix_ready_i) begin
        e = exp_pix(cur_w, cur_mode, cur_bhi, cur_phi, cur_swp, cur_idx);
        vectors++;
        if (pix_o !== e) begin
          fails++;
          $display("FAIL %s R3 R9 R10 pix_o mode %0d idx %0d: actual %06h expected %06h",
                   mode_tag(cur_mode), cur_mode, cur_idx, pix_o, e);
        end
        cur_idx++;
        rem--;
      end
      if (word_valid_i && exp_wr) begin
        cur_w = word_i; cur_mode = mode;
        cur_bhi = combo[2]; cur_phi = combo[1]; cur_swp = combo[0];
        cur_idx = 0; rem = ppw(mode); sent++;
      end
      if (pal_we_i) pal_m[pal_addr_i] = pal_data_i;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    rem = 0; cur_idx = 0; cur_mode = 0; cur_w = '0;
    cur_bhi = 0; cur_phi = 0; cur_swp = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    vectors++;
    if (pix_valid_o !== 1'b0 || word_ready_o !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset state: actual valid %0b ready %0b expected valid 0 ready 1",
               pix_valid_o, word_ready_o);
    end
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      pal_we_i = 1'b1;
      pal_addr_i = 8'(i);
      pal_data_i = {8'(i), 8'(~i), 8'(i ^ 8'h5a)};
      pal_m[i] = pal_data_i;
    end
    @(negedge clk_i);
    pal_we_i = 1'b0;
    for (int m = 0; m < 8; m++)
      for (int c = 0; c < 8; c++)
        run_combo(m, c);
    @(negedge clk_i);
    word_valid_i = 1'b0;
    pix_ready_i  = 1'b0;
    pal_we_i     = 1'b0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule